// File: doc/BRIEF.md
# Core Reset Qualification Controller

This block sits between a processor core's reset pins and the core itself. It takes an active-low hard reset that may arrive at any moment, a PLL lock indication, a soft reset that acts on its falling edge, and five reset configuration pins. From these it builds a qualified internal hard reset, an output-driver enable, a latched copy of the configuration pins with a decoded bus-mode bit, a single-cycle soft-reset request, and a flag for a hard-reset pulse that was too short.

Hard reset takes effect at once, with no clock edge needed. It leaves the core only after a two-flop synchronizer, and only if the pin was held low for a minimum number of consecutive clock edges with the PLL locked. A pulse that is released too early leaves the core in reset and raises the violation flag. The configuration pins are captured on the clock edge that releases the core. A soft reset is detected on its falling edge after synchronization, and it produces a request only while the core is out of hard reset. All ports are plain control and status signals. There is no data stream, so no ready/valid handshake or back-pressure is involved.

Top module: `rstq_ctrl`

## Requirements
- R1: `core_rst_n_o` is 0 whenever `hrst_n_i` is 0, and it falls together with `hrst_n_i` without waiting for a clock edge.
- R2: After `hrst_n_i` rises, `core_rst_n_o` rises on the third rising clock edge. This happens only if, by the edge before that one, the hold counter has seen HOLD_CYCLES consecutive edges with the synchronized hard reset asserted and `pll_lock_i` at 1.
- R3: While hard reset is held, a 0 on `pll_lock_i` clears the hold count. Locked edges before the drop do not count toward HOLD_CYCLES.
- R4: If the release reaches the core before the count completes, `pw_viol_o` goes to 1 and `core_rst_n_o` stays 0. Both stay that way until `hrst_n_i` is asserted again, and that assertion clears `pw_viol_o` at once.
- R5: `drv_en_o` (1 = pads driving, 0 = high impedance) goes to 0 at once when `hrst_n_i` falls, which is well within five cycles. It rises one clock edge after `core_rst_n_o` rises.
- R6: `cfg_o` takes the value of `cfg_i` on the edge that releases the core. It keeps that value until the next qualified release, and a violating release does not update it.
- R7: `bus32_o` is bit 0 of the captured configuration: 1 selects the 32-bit data bus, 0 selects the 64-bit data bus.
- R8: Each falling edge on `srst_n_i` whose low level lasts at least two clock cycles produces exactly one one-cycle pulse on `srst_req_o`. The pulse is high after the third rising edge that follows the fall.
- R9: A soft reset produces no request while `core_rst_n_o` is 0. A level that is already low when the core is released produces no request either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| hrst_n_i | input | 1 | Asynchronous hard reset, active low |
| srst_n_i | input | 1 | Soft reset, acts on its falling edge |
| pll_lock_i | input | 1 | PLL lock indication |
| cfg_i | input | CFG_W | Reset configuration pins |
| core_rst_n_o | output | 1 | Qualified internal hard reset, active low |
| drv_en_o | output | 1 | Output-driver enable, 0 = high impedance |
| cfg_o | output | CFG_W | Configuration latched at release |
| bus32_o | output | 1 | 1 = 32-bit bus mode, 0 = 64-bit |
| srst_req_o | output | 1 | One-cycle soft-reset request |
| pw_viol_o | output | 1 | Hard-reset pulse-width violation |

## Verification
The bench builds the block with HOLD_CYCLES set to 20, so the qualified-release case, the short-pulse case and the lock-drop case each fit in a few dozen cycles. CFG_W stays at 5, which keeps the bus-mode bit and the other captured bits visible together. The short hold makes a clear margin on both sides of the threshold practical. It also lets the bench test a lock drop in which the locked edges add up to more than HOLD_CYCLES but are not consecutive.

// File: rtl/rstq_pkg.sv
package rstq_pkg;
  localparam int unsigned CFG_W_DEF    = 5;
  localparam int unsigned HOLD_DEF     = 255;
  localparam int unsigned MODE_BIT_DEF = 0;
endpackage

// File: rtl/rstq_sync.sv
// Two-flop synchronizer with asynchronous load of RST_VAL.
module rstq_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/rstq_hold_cnt.sv
// Saturating count of consecutive qualified edges.
module rstq_hold_cnt #(
  parameter int unsigned HOLD = 255
) (
  input  logic clk,
  input  logic clr,
  output logic done
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (clr)        cnt_q <= '0;
    else if (!done) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/rstq_srst_edge.sv
// Synchronizes soft reset and emits one pulse per falling edge while armed.
module rstq_srst_edge (
  input  logic clk,
  input  logic arst_n,
  input  logic srst_n,
  input  logic arm,
  output logic req
);
  logic s_sync, prev_q, req_q, fall;

  rstq_sync #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .arst_n(arst_n), .d(srst_n), .q(s_sync)
  );

  assign fall = prev_q & ~s_sync;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      prev_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      prev_q <= s_sync;
      req_q  <= fall & arm;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/rstq_ctrl.sv
module rstq_ctrl
  import rstq_pkg::*;
#(
  parameter int unsigned CFG_W    = CFG_W_DEF,
  parameter int unsigned HOLD     = HOLD_DEF,
  parameter int unsigned MODE_BIT = MODE_BIT_DEF
) (
  input  logic             clk,
  input  logic             hrst_n_i,
  input  logic             srst_n_i,
  input  logic             pll_lock_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             core_rst_n_o,
  output logic             drv_en_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             bus32_o,
  output logic             srst_req_o,
  output logic             pw_viol_o
);
  logic rel_sync, hold_done, decide;
  logic core_q, viol_q, drv_q;
  logic [CFG_W-1:0] cfg_q;

  // async assert, synchronous release of the hard-reset pin
  rstq_sync #(.RST_VAL(1'b0)) u_hsync (
    .clk(clk), .arst_n(hrst_n_i), .d(1'b1), .q(rel_sync)
  );

  rstq_hold_cnt #(.HOLD(HOLD)) u_hold (
    .clk(clk), .clr(rel_sync | ~pll_lock_i), .done(hold_done)
  );

  assign decide = rel_sync & ~core_q & ~viol_q;

  always_ff @(posedge clk or negedge hrst_n_i) begin
    if (!hrst_n_i) begin
      core_q <= 1'b0;
      viol_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      drv_q <= core_q;
      if (decide) begin
        if (hold_done) core_q <= 1'b1;
        else           viol_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (decide && hold_done) cfg_q <= cfg_i;
  end

  rstq_srst_edge u_sedge (
    .clk(clk), .arst_n(hrst_n_i), .srst_n(srst_n_i),
    .arm(core_q), .req(srst_req_o)
  );

  assign core_rst_n_o = core_q;
  assign drv_en_o     = drv_q;
  assign pw_viol_o    = viol_q;
  assign cfg_o        = cfg_q;
  assign bus32_o      = cfg_q[MODE_BIT];
endmodule

// File: rtl/rstq_ctrl_chk.sv
module rstq_ctrl_chk #(
  parameter int unsigned CFG_W = 5
) (
  input logic             clk,
  input logic             hrst_n_i,
  input logic             core_rst_n_o,
  input logic             drv_en_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             srst_req_o,
  input logic             pw_viol_o
);
  // R1
  a_r1_async_assert: assert property (@(posedge clk)
    !hrst_n_i |-> !core_rst_n_o);
  // R4
  a_r4_no_release_on_viol: assert property (@(posedge clk) disable iff (!hrst_n_i)
    pw_viol_o |-> !core_rst_n_o);
  // R5
  a_r5_drv_off_in_reset: assert property (@(posedge clk) disable iff (!hrst_n_i)
    !core_rst_n_o |-> !drv_en_o);
  // R6
  a_r6_cfg_held: assert property (@(posedge clk) disable iff (!hrst_n_i)
    (core_rst_n_o && $past(core_rst_n_o)) |-> $stable(cfg_o));
  // R8
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!hrst_n_i)
    srst_req_o |=> !srst_req_o);
  // R9
  a_r9_req_only_running: assert property (@(posedge clk) disable iff (!hrst_n_i)
    srst_req_o |-> core_rst_n_o);
endmodule

bind rstq_ctrl rstq_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .hrst_n_i(hrst_n_i), .core_rst_n_o(core_rst_n_o),
  .drv_en_o(drv_en_o), .cfg_o(cfg_o), .srst_req_o(srst_req_o),
  .pw_viol_o(pw_viol_o)
);

// File: tb/rstq_ctrl_tb.sv
module rstq_ctrl_tb;
  localparam int unsigned HOLD = 20;
  localparam int unsigned CW   = 5;

  logic clk = 1'b0;
  logic hrst_n_i, srst_n_i, pll_lock_i;
  logic [CW-1:0] cfg_i;
  logic core_rst_n_o, drv_en_o, bus32_o, srst_req_o, pw_viol_o;
  logic [CW-1:0] cfg_o;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  int exp_q[$];
  logic prev_req = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rstq_ctrl #(.CFG_W(CW), .HOLD(HOLD), .MODE_BIT(0)) u_dut (
    .clk(clk), .hrst_n_i(hrst_n_i), .srst_n_i(srst_n_i),
    .pll_lock_i(pll_lock_i), .cfg_i(cfg_i), .core_rst_n_o(core_rst_n_o),
    .drv_en_o(drv_en_o), .cfg_o(cfg_o), .bus32_o(bus32_o),
    .srst_req_o(srst_req_o), .pw_viol_o(pw_viol_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: soft-reset pulse, pushes expected request cycle when it should count
  task automatic srst_pulse(input int len, input bit expect_req);
    @(negedge clk);
    srst_n_i = 1'b0;
    if (expect_req) exp_q.push_back(cyc + 3);
    wait_cyc(len);
    srst_n_i = 1'b1;
  endtask

  // monitor: scoreboard for soft-reset requests (R8, R9)
  always @(negedge clk) begin
    if (srst_req_o === 1'b1) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected request actual=1 expected=0 at cycle %0d", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc || prev_req) begin
          bad++;
          $display("FAIL R8 request cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
    prev_req = srst_req_o;
  end

  task automatic release_hrst();
    @(negedge clk);
    hrst_n_i = 1'b1;
    wait_cyc(2);
  endtask

  initial begin
    hrst_n_i = 1'b0; srst_n_i = 1'b1; pll_lock_i = 1'b0; cfg_i = 5'b10110;
    wait_cyc(3);
    chk("R1 reset core", core_rst_n_o, 0);
    chk("R5 reset drv", drv_en_o, 0);
    chk("R4 reset viol", pw_viol_o, 0);

    // qualified release
    pll_lock_i = 1'b1;
    wait_cyc(HOLD + 4);
    cfg_i = 5'b01011;
    release_hrst();
    chk("R2 still held after two edges", core_rst_n_o, 0);
    wait_cyc(1);
    chk("R2 released on third edge", core_rst_n_o, 1);
    chk("R4 no viol", pw_viol_o, 0);
    chk("R5 drv still off", drv_en_o, 0);
    chk("R6 cfg captured", cfg_o, 5'b01011);
    chk("R7 bus32 set", bus32_o, 1);
    wait_cyc(1);
    chk("R5 drv on", drv_en_o, 1);
    cfg_i = 5'b00000;
    wait_cyc(3);
    chk("R6 cfg held", cfg_o, 5'b01011);

    // soft resets while running
    srst_pulse(2, 1'b1);
    wait_cyc(6);
    srst_pulse(4, 1'b1);
    wait_cyc(6);

    // hard reset assertion, checked before any clock edge
    @(negedge clk);
    hrst_n_i = 1'b0;
    #1;
    chk("R1 immediate assert", core_rst_n_o, 0);
    chk("R5 immediate drv off", drv_en_o, 0);
    srst_pulse(3, 1'b0);
    wait_cyc(5);

    // short pulse: violation
    release_hrst();
    wait_cyc(HOLD);
    chk("R4 viol flagged", pw_viol_o, 1);
    chk("R4 core held", core_rst_n_o, 0);
    chk("R6 cfg not updated", cfg_o, 5'b01011);
    srst_pulse(3, 1'b0);
    wait_cyc(6);

    // lock drop splits the count
    @(negedge clk);
    hrst_n_i = 1'b0;
    #1;
    chk("R4 viol cleared", pw_viol_o, 0);
    wait_cyc(HOLD - 4);
    pll_lock_i = 1'b0;
    wait_cyc(1);
    pll_lock_i = 1'b1;
    wait_cyc(HOLD - 6);
    release_hrst();
    wait_cyc(3);
    chk("R3 viol after lock drop", pw_viol_o, 1);
    chk("R3 core held", core_rst_n_o, 0);

    // good release with soft reset already low
    @(negedge clk);
    hrst_n_i = 1'b0;
    cfg_i = 5'b11100;
    srst_n_i = 1'b0;
    wait_cyc(HOLD + 4);
    release_hrst();
    wait_cyc(1);
    chk("R2 release", core_rst_n_o, 1);
    chk("R7 bus64", bus32_o, 0);
    chk("R6 new cfg", cfg_o, 5'b11100);
    wait_cyc(5);
    srst_n_i = 1'b1;
    wait_cyc(5);
    srst_pulse(2, 1'b1);
    wait_cyc(8);

    chk("R8 all requests seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule